// File: doc/BRIEF.md
# Ternary-weight convolution adder network

This block computes every filter output of one convolution layer for a single flattened window per clock cycle, without any multiplier. Each filter weight is restricted to -1, 0 or +1; the magnitude scale of the layer is kept outside and applied downstream, so an output is a plain signed sum of the window values whose weight is +1 minus the sum of those whose weight is -1.

The work is split into two pipelined tiers. A first tier forms a set of shared partial sums (each a ternary combination of window values) once for all filters. A second tier forms each filter output as a ternary combination of the window values and those shared partial sums. Both tables are elaboration-time parameters, prepared offline by a subexpression search. Every add or subtract level ends in a register, so a new window can be presented on every cycle, and a valid flag travels alongside the data through a matching shift chain.

The surrounding line buffer that forms windows, the scale factor, normalisation and activation belong to other blocks.

Top module: `tern_conv_top`

## Requirements
- R1: A coefficient is a 2-bit code: 2'b01 means +1, 2'b11 means -1, 2'b00 and 2'b10 mean 0. Shared term k takes its code for window value i from SHR_CF bits [(k*64+i)*2 +: 2]; filter o takes its code for operand j from FLT_CF bits [(o*64+j)*2 +: 2], where operands 0..NIN-1 are the window values and operand NIN+k is shared term k. Window value i is in_win[i*IW +: IW], two's complement.
- R2: Filter output o, at out_sum[o*OW +: OW], equals the exact integer sum of code times operand over all operands, for every input combination including the most negative and most positive input values.
- R3: out_vld rises exactly LAT = 2 + clog2(NIN) + clog2(NIN+NSHR) cycles after the edge that accepted the window, carrying that window's results.
- R4: A window is accepted on every cycle with in_vld high, back to back, and results leave in the order the windows arrived, one per cycle.
- R5: While out_vld is low, out_sum keeps the value of the most recent result; a window presented with in_vld low changes nothing.
- R6: While rst_n is low and until the first accepted window has crossed the pipeline, out_vld is low.
- R7: An all-zero window yields all-zero outputs.
- R8: OW = IW + clog2(NIN+1) + clog2(NIN+NSHR+1), wide enough that no sum wraps.
- R9: A filter whose codes are all zero outputs zero for every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Window on in_win is to be accepted this cycle |
| in_win | input | NIN*IW | Flattened window, value i in bits [i*IW +: IW] |
| out_vld | output | 1 | out_sum carries a new result this cycle |
| out_sum | output | NOUT*OW | Filter results, filter o in bits [o*OW +: OW] |

## Verification
A wrong code decode, a dropped carry or a misaligned shared term shows up as a wrong value on one or more filter lanes exactly LAT cycles after the offending window, and the exhaustive sweep over a small configuration reaches every input combination, so such a fault appears within the first few thousand cycles. A valid chain that is one stage too short or long shows as a latency mismatch on the very first window, and a data register that loads without a valid shows as out_sum moving during the bubbles of the gapped phase.

// File: rtl/tern_pkg.sv
package tern_pkg;

  // Row stride of the coefficient tables: at most 64 operands and 64 rows.
  localparam int MAX_OPS   = 64;
  localparam int MAX_ROWS  = 64;
  localparam int COEF_BITS = 2 * MAX_OPS * MAX_ROWS;

  typedef logic [1:0] tcode_t;
  localparam tcode_t T_POS = 2'b01;
  localparam tcode_t T_NEG = 2'b11;

  // Number of nodes at level l of a tree that halves (rounding up) per level.
  function automatic int lvl_cnt(input int n, input int l);
    return (n + (1 << l) - 1) >> l;
  endfunction

  // Filler table for default elaboration: pseudo-random codes.
  function automatic logic [COEF_BITS-1:0] demo_table(input int seed);
    logic [COEF_BITS-1:0] t;
    logic [31:0]          s;
    s = seed;
    t = '0;
    for (int i = 0; i < MAX_OPS * MAX_ROWS; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      t[2*i +: 2] = s[17:16];
    end
    return t;
  endfunction

endpackage

// File: rtl/tern_term_tree.sv
module tern_term_tree
  import tern_pkg::*;
#(
  parameter int              N  = 4,
  parameter int              IW = 8,
  parameter int              W  = 12,
  parameter logic [2*N-1:0]  CF = '0,
  localparam int             LV    = $clog2(N),
  localparam int             DEPTH = LV + 1
) (
  input  logic                 clk,
  input  logic [DEPTH-1:0]     en,
  input  logic signed [IW-1:0] op [N],
  output logic signed [W-1:0]  sum
);

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int C = lvl_cnt(N, l);
    logic signed [W-1:0] d [C];
    logic signed [W-1:0] q [C];

    if (l == 0) begin : g_leaf
      // Code decode: sign, negate or drop each operand.
      always_comb begin
        for (int i = 0; i < C; i++) begin
          case (CF[2*i +: 2])
            T_POS:   d[i] = W'(op[i]);
            T_NEG:   d[i] = -W'(op[i]);
            default: d[i] = '0;
          endcase
        end
      end
    end else begin : g_add
      localparam int PC = lvl_cnt(N, l - 1);
      always_comb begin
        for (int j = 0; j < C; j++) begin
          if (2*j + 1 < PC) d[j] = g_lv[l-1].q[2*j] + g_lv[l-1].q[2*j+1];
          else              d[j] = g_lv[l-1].q[2*j];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (en[l]) q <= d;
    end
  end

  assign sum = g_lv[LV].q[0];

endmodule

// File: rtl/tern_delay.sv
module tern_delay #(
  parameter int N = 4,
  parameter int W = 8,
  parameter int D = 3
) (
  input  logic                clk,
  input  logic [D-1:0]        en,
  input  logic signed [W-1:0] din  [N],
  output logic signed [W-1:0] dout [N]
);

  for (genvar s = 0; s < D; s++) begin : g_st
    logic signed [W-1:0] q [N];
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (en[s]) q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (en[s]) q <= g_st[s-1].q;
      end
    end
  end

  assign dout = g_st[D-1].q;

endmodule

// File: rtl/tern_conv_top.sv
module tern_conv_top
  import tern_pkg::*;
#(
  parameter int                   NIN    = 27,
  parameter int                   IW     = 16,
  parameter int                   NSHR   = 4,
  parameter int                   NOUT   = 64,
  parameter logic [COEF_BITS-1:0] SHR_CF = demo_table(7),
  parameter logic [COEF_BITS-1:0] FLT_CF = demo_table(11),
  localparam int                  SW   = IW + $clog2(NIN + 1),
  localparam int                  NOP  = NIN + NSHR,
  localparam int                  OW   = SW + $clog2(NOP + 1),
  localparam int                  D1   = $clog2(NIN) + 1,
  localparam int                  D2   = $clog2(NOP) + 1,
  localparam int                  LAT  = D1 + D2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [NIN*IW-1:0]   in_win,
  output logic                out_vld,
  output logic [NOUT*OW-1:0]  out_sum
);

  // Valid chain: stage_en[k] qualifies the load of pipeline stage k.
  logic [LAT-1:0] vld_d, vld_q, stage_en;

  assign stage_en = {vld_q[LAT-2:0], in_vld};

  always_comb begin
    vld_d = stage_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign out_vld = vld_q[LAT-1];

  // Window unpack.
  logic signed [IW-1:0] win [NIN];
  always_comb begin
    for (int i = 0; i < NIN; i++) win[i] = in_win[i*IW +: IW];
  end

  // Tier 1: shared partial sums, with the raw window delayed alongside.
  logic signed [SW-1:0] shr     [NSHR];
  logic signed [IW-1:0] win_dly [NIN];

  for (genvar k = 0; k < NSHR; k++) begin : g_shr
    localparam logic [2*NIN-1:0] CFK = SHR_CF[k*2*MAX_OPS +: 2*NIN];
    logic signed [SW-1:0] s;
    tern_term_tree #(.N(NIN), .IW(IW), .W(SW), .CF(CFK)) u_tree (
      .clk (clk),
      .en  (stage_en[D1-1:0]),
      .op  (win),
      .sum (s)
    );
    assign shr[k] = s;
  end

  tern_delay #(.N(NIN), .W(IW), .D(D1)) u_win_dly (
    .clk  (clk),
    .en   (stage_en[D1-1:0]),
    .din  (win),
    .dout (win_dly)
  );

  // Tier 2: one tree per filter over window values and shared terms.
  logic signed [SW-1:0] ops [NOP];
  always_comb begin
    for (int i = 0; i < NIN; i++)  ops[i]       = SW'(win_dly[i]);
    for (int k = 0; k < NSHR; k++) ops[NIN + k] = shr[k];
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_flt
    localparam logic [2*NOP-1:0] CFO = FLT_CF[o*2*MAX_OPS +: 2*NOP];
    logic signed [OW-1:0] s;
    tern_term_tree #(.N(NOP), .IW(SW), .W(OW), .CF(CFO)) u_tree (
      .clk (clk),
      .en  (stage_en[LAT-1:D1]),
      .op  (ops),
      .sum (s)
    );
    assign out_sum[o*OW +: OW] = s;
  end

endmodule

// File: rtl/tern_conv_chk.sv
module tern_conv_chk #(
  parameter int LAT  = 7,
  parameter int INW  = 12,
  parameter int OUTW = 54
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic [INW-1:0]  in_win,
  input logic            out_vld,
  input logic [OUTW-1:0] out_sum
);

  logic [7:0] age;
  logic       got;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
      got <= 1'b0;
    end else begin
      if (age != 8'hFF) age <= age + 8'd1;
      if (out_vld)      got <= 1'b1;
    end
  end

  // R3
  lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(age) >= LAT) |-> (out_vld == $past(in_vld, LAT)));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (got && !out_vld) |-> $stable(out_sum));

  // R7
  zero_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(age) >= LAT) && out_vld && ($past(in_win, LAT) == '0)) |-> (out_sum == '0));

  // R6
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!out_vld);
    end
  end

endmodule

bind tern_conv_top tern_conv_chk #(.LAT(LAT), .INW(NIN*IW), .OUTW(NOUT*OW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .in_win  (in_win),
  .out_vld (out_vld),
  .out_sum (out_sum)
);

// File: tb/test_tern_conv_top.sv
`timescale 1ns/1ps
module test_tern_conv_top;

  localparam int NIN  = 4;
  localparam int IW   = 3;
  localparam int NSHR = 2;
  localparam int NOUT = 6;
  localparam int NOP  = NIN + NSHR;
  localparam int OW   = 9;   // R8: 3 + clog2(5) + clog2(7)
  localparam int LAT  = 7;   // R3: 2 + clog2(4) + clog2(6)
  localparam int CB   = tern_pkg::COEF_BITS;

  function automatic logic [CB-1:0] mk_shr();
    logic [CB-1:0] t;
    t = '0;
    t[(0*64+0)*2 +: 2] = 2'b01;
    t[(0*64+1)*2 +: 2] = 2'b01;
    t[(1*64+0)*2 +: 2] = 2'b11;
    t[(1*64+1)*2 +: 2] = 2'b10;
    t[(1*64+2)*2 +: 2] = 2'b01;
    t[(1*64+3)*2 +: 2] = 2'b11;
    return t;
  endfunction

  function automatic logic [CB-1:0] mk_flt();
    logic [CB-1:0] t;
    logic [1:0]    c;
    t = '0;
    for (int o = 0; o < NOUT; o++) begin
      for (int j = 0; j < NOP; j++) begin
        if (o == 0)      c = (j < NIN) ? 2'b01 : 2'b00;
        else if (o == 1) c = 2'b11;
        else if (o == 5) c = 2'b00;
        else begin
          case ((o*7 + j*3) % 4)
            0: c = 2'b00;
            1: c = 2'b01;
            2: c = 2'b11;
            default: c = 2'b10;
          endcase
        end
        t[(o*64+j)*2 +: 2] = c;
      end
    end
    return t;
  endfunction

  localparam logic [CB-1:0] SHR_T = mk_shr();
  localparam logic [CB-1:0] FLT_T = mk_flt();

  logic                 clk, rst_n, in_vld, out_vld;
  logic [NIN*IW-1:0]    in_win;
  logic [NOUT*OW-1:0]   out_sum;

  tern_conv_top #(.NIN(NIN), .IW(IW), .NSHR(NSHR), .NOUT(NOUT),
                  .SHR_CF(SHR_T), .FLT_CF(FLT_T)) i_tern_conv_top (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_win (in_win),
    .out_vld (out_vld), .out_sum (out_sum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, sent = 0, rcv = 0;
  bit done = 0, got = 0;
  int exp_q [16][NOUT];
  int in_cyc [16];
  bit zero_q [16];
  logic [NOUT*OW-1:0] last_sum;

  // R1 decode rule
  function automatic int dec(input logic [1:0] c);
    return (c == 2'b01) ? 1 : ((c == 2'b11) ? -1 : 0);
  endfunction

  function automatic int xval(input logic [NIN*IW-1:0] w, input int i);
    logic signed [IW-1:0] v;
    v = w[i*IW +: IW];
    return int'(v);
  endfunction

  task automatic record(input logic [NIN*IW-1:0] w);
    int x [NOP];
    int slot;
    slot = sent % 16;
    for (int i = 0; i < NIN; i++) x[i] = xval(w, i);
    for (int k = 0; k < NSHR; k++) begin
      x[NIN+k] = 0;
      for (int i = 0; i < NIN; i++) x[NIN+k] += dec(SHR_T[(k*64+i)*2 +: 2]) * x[i];
    end
    for (int o = 0; o < NOUT; o++) begin
      exp_q[slot][o] = 0;
      for (int j = 0; j < NOP; j++) exp_q[slot][o] += dec(FLT_T[(o*64+j)*2 +: 2]) * x[j];
    end
    in_cyc[slot] = cyc;
    zero_q[slot] = (w == '0);
    sent++;
  endtask

  task automatic drive(input logic [NIN*IW-1:0] w, input bit v);
    @(negedge clk);
    in_win = w;
    in_vld = v;
    if (v) record(w);
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        int slot;
        bit bad;
        logic signed [OW-1:0] a;
        slot = rcv % 16;
        checks++;
        if (cyc - in_cyc[slot] != LAT) begin
          fails++;
          $display("FAIL R3 R4 window %0d latency actual=%0d expected=%0d", rcv, cyc - in_cyc[slot], LAT);
        end
        bad = 0;
        for (int o = 0; o < NOUT; o++) begin
          a = out_sum[o*OW +: OW];
          if (int'(a) != exp_q[slot][o]) begin
            bad = 1;
            $display("FAIL R1 R2 R8 window %0d filter %0d actual=%0d expected=%0d", rcv, o, int'(a), exp_q[slot][o]);
          end
        end
        checks++;
        if (bad) fails++;
        // R9: all-zero filter
        a = out_sum[5*OW +: OW];
        checks++;
        if (a != 0) begin
          fails++;
          $display("FAIL R9 window %0d actual=%0d expected=0", rcv, int'(a));
        end
        if (zero_q[slot]) begin
          checks++;
          if (out_sum != '0) begin
            fails++;
            $display("FAIL R7 actual=%h expected=0", out_sum);
          end
        end
        last_sum = out_sum;
        got = 1;
        rcv++;
      end else if (got) begin
        checks++;
        if (out_sum != last_sum) begin
          fails++;
          $display("FAIL R5 actual=%h expected=%h", out_sum, last_sum);
        end
      end
    end
  end

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8ns * 60000);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog received=%0d expected=%0d", rcv, sent);
      finish_up();
    end
  end

  initial begin
    logic [31:0] s;
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_win = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      fails++;
      $display("FAIL R6 in reset out_vld actual=%b expected=0", out_vld);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      fails++;
      $display("FAIL R6 after reset out_vld actual=%b expected=0", out_vld);
    end

    // R2 R4 R7 R8: every window of the small configuration, back to back.
    for (int w = 0; w < (1 << (NIN*IW)); w++) drive(w[NIN*IW-1:0], 1'b1);

    // R5: gapped traffic; idle cycles carry changing, ignored data.
    s = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      s = s * 32'd1103515245 + 32'd12345;
      drive(s[27:16], s[30] | s[29]);
    end
    drive('1, 1'b1);
    drive({NIN{3'b100}}, 1'b1);
    drive({NIN{3'b011}}, 1'b1);
    for (int n = 0; n < 20; n++) drive(12'(n * 37), 1'b0);

    checks++;
    if (rcv != sent) begin
      fails++;
      $display("FAIL R4 result count actual=%0d expected=%0d", rcv, sent);
    end
    finish_up();
  end

endmodule